// File: doc/BRIEF.md
# Subranging Conversion Error-Correction Combiner

This block turns the four partial codes of a four-step subranging conversion into one 12-bit sample. A sequencer presents, in order, a 3-bit first-flash code, a 3-bit second-flash code, a 4-bit coarse backend code and a 4-bit fine backend code, each with a one-cycle strobe. The second and coarse stages each resolve one redundant bit. The block reads them as signed corrections around the middle of their span, so that an error made by an earlier stage is absorbed by a carry or borrow in the sum rather than producing a wrong code.

A start pulse opens a conversion and clears the running partial sum. The partial sum grows as each stage code is accepted. When the fine code arrives, the corrected sum is clamped, forced to a rail when the analog side signals out-of-range, and registered together with a one-cycle valid pulse. A format select turns the offset-binary word into two's complement by inverting its top bit. A separate output always carries the inverted top bit of the offset-binary word.

Top module: `subrange_corr`

## Requirements
- R1: After reset, data_out is 0, msb_n is 1, out_of_range is 0 and data_valid is 0.
- R2: For stage codes a, b, c, d, the offset-binary word is a*512 + (b-2)*128 + (c-4)*16 + d, clamped to 0..4095. It appears on data_out (with fmt_twos=0) after the rising edge that accepts the fine strobe.
- R3: A corrected sum above 4095 gives 4095 and a sum below 0 gives 0. In both cases out_of_range is set.
- R4: If over_in is high with an accepted fine strobe, the word becomes all ones and out_of_range is set. If under_in is high and over_in is low, the word becomes all zeros and out_of_range is set. over_in takes precedence over under_in.
- R5: out_of_range and the word hold their values between completed conversions. A completed conversion that is in range and not clamped clears out_of_range.
- R6: Stage strobes are accepted only in the order first, second, coarse, fine, and only after a start. A strobe arriving out of that order is ignored and has no effect on the result. A fine strobe with no complete sequence before it produces no data_valid.
- R7: A start pulse discards any partial sum and restarts the sequence. The held output is unchanged until the next result becomes valid.
- R8: With fmt_twos=1, bit 11 of data_out is the inverse of bit 11 of the offset-binary word, and the other bits are unchanged. msb_n is always the inverse of bit 11 of the offset-binary word.
- R9: data_valid is high for exactly one cycle per completed conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| conv_start | input | 1 | Opens a conversion, clears partial sum |
| st1_code | input | 3 | First-flash code |
| st1_stb | input | 1 | First-flash strobe |
| st2_code | input | 3 | Second-flash code (one redundant bit) |
| st2_stb | input | 1 | Second-flash strobe |
| st3_code | input | 4 | Coarse backend code (one redundant bit) |
| st3_stb | input | 1 | Coarse backend strobe |
| st4_code | input | 4 | Fine backend code |
| st4_stb | input | 1 | Fine backend strobe |
| over_in | input | 1 | Analog input above range, sampled with fine strobe |
| under_in | input | 1 | Analog input below range, sampled with fine strobe |
| fmt_twos | input | 1 | 1 selects two's complement output |
| data_out | output | 12 | Result word |
| msb_n | output | 1 | Inverted top bit of offset-binary word |
| out_of_range | output | 1 | Out-of-range flag |
| data_valid | output | 1 | One-cycle result pulse |

## Verification
Each stage code is taken on the rising edge where its strobe is high. The result word, the range flag and data_valid change on the same edge that accepts the fine strobe, so they are due one edge after the fine strobe is driven. data_valid drops again one edge later. The bench drives every input on the falling edge. It samples the outputs on the following falling edge, and for the pulse-width check on the falling edge after that. Checks of the held value are made on falling edges in the middle of a partial sequence, before the fine code is given.

// File: rtl/subrange_corr_pkg.sv
package subrange_corr_pkg;

  // Contribution of one stage code to the corrected sum.
  // Centred stages subtract a quarter of their code span so that the
  // redundant bit can carry a correction in either direction.
  function automatic int stage_term(input int code, input int width,
                                    input int shift, input bit centred);
    int off;
    off = centred ? (1 << (width - 2)) : 0;
    return (code - off) * (1 << shift);
  endfunction

  // Clamp a signed sum to the unsigned range of an res-bit word.
  function automatic int clamp_word(input int sum, input int res);
    int top;
    top = (1 << res) - 1;
    if (sum < 0) return 0;
    if (sum > top) return top;
    return sum;
  endfunction

endpackage

// File: rtl/subrange_seq.sv
module subrange_seq #(
  parameter int STAGES = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [STAGES-1:0] stb,
  output logic [STAGES-1:0] take,
  output logic              fire
);
  localparam int PW = $clog2(STAGES + 1);

  // 0 = idle, k = waiting for stage k
  logic [PW-1:0] exp_q;

  for (genvar k = 0; k < STAGES; k++) begin : g_take
    assign take[k] = stb[k] && !start && (exp_q == PW'(k + 1));
  end

  assign fire = take[STAGES-1];

  always_ff @(posedge clk) begin
    if (!rst_n)       exp_q <= '0;
    else if (start)   exp_q <= PW'(1);
    else if (|take)   exp_q <= (exp_q == PW'(STAGES)) ? '0 : exp_q + PW'(1);
  end

  p_take_onehot_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(take));

  p_start_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> !fire);

endmodule

// File: rtl/subrange_accum.sv
module subrange_accum #(
  parameter int W1    = 3,
  parameter int W2    = 3,
  parameter int W3    = 4,
  parameter int W4    = 4,
  parameter int ACC_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic [2:0]              take_part,
  input  logic [W1-1:0]           code1,
  input  logic [W2-1:0]           code2,
  input  logic [W3-1:0]           code3,
  input  logic [W4-1:0]           code4,
  output logic signed [ACC_W-1:0] fine_sum
);
  import subrange_corr_pkg::*;

  localparam int SH4 = 0;
  localparam int SH3 = SH4 + W4;
  localparam int SH2 = SH3 + W3 - 1;
  localparam int SH1 = SH2 + W2 - 1;

  logic signed [ACC_W-1:0] term [4];
  logic signed [ACC_W-1:0] acc_q;

  assign term[0] = ACC_W'(stage_term(int'(code1), W1, SH1, 1'b0));
  assign term[1] = ACC_W'(stage_term(int'(code2), W2, SH2, 1'b1));
  assign term[2] = ACC_W'(stage_term(int'(code3), W3, SH3, 1'b1));
  assign term[3] = ACC_W'(stage_term(int'(code4), W4, SH4, 1'b0));

  always_ff @(posedge clk) begin
    if (!rst_n || start) begin
      acc_q <= '0;
    end else begin
      for (int k = 0; k < 3; k++) begin
        if (take_part[k]) acc_q <= acc_q + term[k];
      end
    end
  end

  assign fine_sum = acc_q + term[3];

  p_start_clears_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start |=> (acc_q == '0));

endmodule

// File: rtl/subrange_out.sv
module subrange_out #(
  parameter int RES   = 12,
  parameter int ACC_W = 14
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    fire,
  input  logic signed [ACC_W-1:0] fine_sum,
  input  logic                    over_in,
  input  logic                    under_in,
  output logic [RES-1:0]          word_q,
  output logic                    oor_q,
  output logic                    valid_q,
  output logic                    sat_hi,
  output logic                    sat_lo
);
  localparam logic signed [ACC_W-1:0] MAXV = ACC_W'((1 << RES) - 1);

  logic [RES-1:0] word_d;
  logic           oor_d;

  assign sat_hi = fine_sum > MAXV;
  assign sat_lo = fine_sum < 0;

  always_comb begin
    word_d = fine_sum[RES-1:0];
    if (sat_lo)   word_d = '0;
    if (sat_hi)   word_d = '1;
    if (under_in) word_d = '0;
    if (over_in)  word_d = '1;
    oor_d = over_in || under_in || sat_hi || sat_lo;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      word_q  <= '0;
      oor_q   <= 1'b0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= fire;
      if (fire) begin
        word_q <= word_d;
        oor_q  <= oor_d;
      end
    end
  end

  p_valid_follows_r2: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> valid_q);

  p_valid_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |-> $past(fire));

  p_pulse_width_r9: assert property (@(posedge clk) disable iff (!rst_n)
    valid_q |=> !valid_q);

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(word_q) && $stable(oor_q)));

  p_over_rail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && over_in) |=> (oor_q && (&word_q)));

  p_under_rail_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && under_in && !over_in) |=> (oor_q && (word_q == '0)));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sat_hi) |=> (oor_q && (&word_q)));

endmodule

// File: rtl/subrange_corr.sv
module subrange_corr #(
  parameter int W1 = 3,
  parameter int W2 = 3,
  parameter int W3 = 4,
  parameter int W4 = 4,
  localparam int RES   = W1 + (W2 - 1) + (W3 - 1) + W4,
  localparam int ACC_W = RES + 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           conv_start,
  input  logic [W1-1:0]  st1_code,
  input  logic           st1_stb,
  input  logic [W2-1:0]  st2_code,
  input  logic           st2_stb,
  input  logic [W3-1:0]  st3_code,
  input  logic           st3_stb,
  input  logic [W4-1:0]  st4_code,
  input  logic           st4_stb,
  input  logic           over_in,
  input  logic           under_in,
  input  logic           fmt_twos,
  output logic [RES-1:0] data_out,
  output logic           msb_n,
  output logic           out_of_range,
  output logic           data_valid
);
  logic [3:0]              take;
  logic                    fire;
  logic signed [ACC_W-1:0] fine_sum;
  logic [RES-1:0]          word_q;
  logic                    sat_hi;
  logic                    sat_lo;

  subrange_seq #(.STAGES(4)) u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .start (conv_start),
    .stb   ({st4_stb, st3_stb, st2_stb, st1_stb}),
    .take  (take),
    .fire  (fire)
  );

  subrange_accum #(.W1(W1), .W2(W2), .W3(W3), .W4(W4), .ACC_W(ACC_W)) u_acc (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (conv_start),
    .take_part (take[2:0]),
    .code1     (st1_code),
    .code2     (st2_code),
    .code3     (st3_code),
    .code4     (st4_code),
    .fine_sum  (fine_sum)
  );

  subrange_out #(.RES(RES), .ACC_W(ACC_W)) u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .fire     (fire),
    .fine_sum (fine_sum),
    .over_in  (over_in),
    .under_in (under_in),
    .word_q   (word_q),
    .oor_q    (out_of_range),
    .valid_q  (data_valid),
    .sat_hi   (sat_hi),
    .sat_lo   (sat_lo)
  );

  assign data_out = fmt_twos ? {~word_q[RES-1], word_q[RES-2:0]} : word_q;
  assign msb_n    = ~word_q[RES-1];

  p_low_clamp_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && sat_lo && !over_in) |=> (out_of_range && (word_q == '0)));

endmodule

// File: tb/sim_subrange_corr.sv
module sim_subrange_corr;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        conv_start = 1'b0;
  logic [2:0]  st1_code = '0;
  logic        st1_stb = 1'b0;
  logic [2:0]  st2_code = '0;
  logic        st2_stb = 1'b0;
  logic [3:0]  st3_code = '0;
  logic        st3_stb = 1'b0;
  logic [3:0]  st4_code = '0;
  logic        st4_stb = 1'b0;
  logic        over_in = 1'b0;
  logic        under_in = 1'b0;
  logic        fmt_twos = 1'b0;
  logic [11:0] data_out;
  logic        msb_n;
  logic        out_of_range;
  logic        data_valid;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  subrange_corr u0 (.*);

  task automatic chk(input string req, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0d expected %0d", req, got, exp);
    end
  endtask

  // Expected raw sum restated: weighted codes minus fixed centring offset.
  function automatic int raw_sum(input int a, input int b, input int c, input int d);
    return a * 512 + b * 128 + c * 16 + d - (2 * 128 + 4 * 16);
  endfunction

  function automatic int exp_word(input int s);
    return (s > 4095) ? 4095 : ((s < 0) ? 0 : s);
  endfunction

  // step: 0 = start, 1..4 = stage strobe, 5 = idle
  task automatic step(input int k, input int code, input bit ov, input bit un);
    @(negedge clk);
    conv_start = (k == 0);
    st1_stb = (k == 1); st2_stb = (k == 2); st3_stb = (k == 3); st4_stb = (k == 4);
    if (k == 1) st1_code = 3'(code);
    if (k == 2) st2_code = 3'(code);
    if (k == 3) st3_code = 4'(code);
    if (k == 4) st4_code = 4'(code);
    over_in = ov; under_in = un;
  endtask

  task automatic convert(input int a, input int b, input int c, input int d,
                         input bit ov, input bit un);
    step(0, 0, 0, 0);
    step(1, a, 0, 0);
    step(2, b, 0, 0);
    step(3, c, 0, 0);
    step(4, d, ov, un);
    step(5, 0, 0, 0);  // outputs of the fine edge visible here
  endtask

  initial begin
    repeat (180000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int s;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 data", int'(data_out), 0);
    chk("R1 msb_n", int'(msb_n), 1);
    chk("R1 oor", int'(out_of_range), 0);
    chk("R1 valid", int'(data_valid), 0);
    @(negedge clk); rst_n = 1'b1;

    // R2/R3 exhaustive sweep, offset binary
    for (int a = 0; a < 8; a++)
      for (int b = 0; b < 8; b++)
        for (int c = 0; c < 16; c++)
          for (int d = 0; d < 16; d++) begin
            convert(a, b, c, d, 0, 0);
            s = raw_sum(a, b, c, d);
            chk("R2 valid", int'(data_valid), 1);
            chk("R2 data", int'(data_out), exp_word(s));
            chk("R3 oor", int'(out_of_range), (s < 0 || s > 4095) ? 1 : 0);
          end

    // R3 explicit corners
    convert(7, 7, 15, 15, 0, 0);
    chk("R3 high clamp", int'(data_out), 4095);
    chk("R3 high flag", int'(out_of_range), 1);
    convert(0, 0, 0, 0, 0, 0);
    chk("R3 low clamp", int'(data_out), 0);
    chk("R3 low flag", int'(out_of_range), 1);

    // R9 pulse width
    convert(3, 2, 4, 5, 0, 0);
    chk("R9 valid high", int'(data_valid), 1);
    step(5, 0, 0, 0);
    chk("R9 valid low", int'(data_valid), 0);

    // R4 forced rails
    convert(3, 2, 4, 5, 1, 0);
    chk("R4 over data", int'(data_out), 4095);
    chk("R4 over flag", int'(out_of_range), 1);
    convert(3, 2, 4, 5, 0, 1);
    chk("R4 under data", int'(data_out), 0);
    chk("R4 under flag", int'(out_of_range), 1);
    convert(3, 2, 4, 5, 1, 1);
    chk("R4 over wins", int'(data_out), 4095);

    // R5 flag held, then cleared by an in-range conversion
    repeat (5) step(5, 0, 0, 0);
    chk("R5 flag held", int'(out_of_range), 1);
    chk("R5 data held", int'(data_out), 4095);
    convert(3, 2, 4, 5, 0, 0);
    chk("R5 flag cleared", int'(out_of_range), 0);
    chk("R5 data", int'(data_out), raw_sum(3, 2, 4, 5));

    // R6 out-of-order strobes ignored
    step(0, 0, 0, 0);
    step(2, 7, 0, 0);        // second before first: ignored
    step(1, 4, 0, 0);
    step(3, 15, 0, 0);       // coarse before second: ignored
    step(2, 3, 0, 0);
    step(3, 6, 0, 0);
    step(4, 9, 0, 0);
    step(5, 0, 0, 0);
    chk("R6 order data", int'(data_out), raw_sum(4, 3, 6, 9));
    // fine strobe with no sequence: no valid, no change
    step(4, 1, 1, 0);
    step(5, 0, 0, 0);
    chk("R6 lone fine valid", int'(data_valid), 0);
    chk("R6 lone fine data", int'(data_out), raw_sum(4, 3, 6, 9));
    chk("R6 lone fine flag", int'(out_of_range), 0);

    // R7 restart discards partial sum, output held meanwhile
    step(0, 0, 0, 0);
    step(1, 7, 0, 0);
    step(2, 6, 0, 0);
    step(5, 0, 0, 0);
    chk("R7 held mid", int'(data_out), raw_sum(4, 3, 6, 9));
    convert(1, 2, 3, 4, 0, 0);
    chk("R7 restart data", int'(data_out), raw_sum(1, 2, 3, 4));

    // R8 format select
    convert(5, 2, 4, 0, 0, 0);   // 2560, top bit set
    chk("R8 offset", int'(data_out), 2560);
    chk("R8 msb_n set", int'(msb_n), 0);
    fmt_twos = 1'b1;
    step(5, 0, 0, 0);
    chk("R8 twos", int'(data_out), 2560 - 2048);
    convert(1, 2, 4, 3, 0, 0);   // 515, top bit clear
    chk("R8 twos neg", int'(data_out), 515 + 2048);
    chk("R8 msb_n clear", int'(msb_n), 1);
    fmt_twos = 1'b0;

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule